// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block turns one request for a raw NAND page read into the ordered list of bus micro-operations that a lower-level flash bus engine executes: command bytes, address bytes, a busy wait and a data-in burst. Each micro-op carries a post-delay in clock cycles, so the engine knows how long to hold off before the next one. The block can also run a shorter sequence that moves the column pointer inside a page that is already loaded in the device's page register, and then reads data from that column.

The caller gives a page number, a byte offset, a transfer length, a flag saying whether the device needs a third row-address byte, a flag for a 16-bit data bus, and the kind of sequence. The inputs are captured when `start_i` is accepted. Micro-ops go out one at a time over a valid/ready handshake. The engine answers each accepted op with a response pulse that may flag an error. An error stops the sequence at once. When the sequence ends, with or without an error, `done_o` pulses for one cycle.

Top module: `nand_page_rd_seq`

## Requirements
- R1: While reset is asserted and right after it, `uop_valid_o`, `done_o`, `err_o` and `busy_o` are low.
- R2: With `mode_i`=0 (full read) the ops are, in order: command 0x00, two column bytes, the row bytes, command 0x30, one wait op, then one data-in op. Kind codes on `uop_kind_o` are 0=command, 1=address, 2=wait, 3=data-in. The command opcode or address byte is on `uop_byte_o`, and `uop_byte_o` is 0 for wait and data-in ops.
- R3: The column is sent as two address bytes, low byte first. When `bus16_i`=1 the column is `offset_i` shifted right by one; otherwise it is `offset_i`.
- R4: The row is sent as `page_i[7:0]` then `page_i[15:8]`, followed by `page_i[23:16]` only when `big_dev_i`=1.
- R5: Post-delays on `uop_dly_o` are 12 cycles for command 0x30, 4 cycles for the wait op, 40 cycles for command 0xE0 and 0 for every other op. The wait op carries the maximum array-read time of 250 cycles on `uop_arg_o`.
- R6: The data-in op carries `len_i` on `uop_arg_o`. A full read with `len_i`=0 issues no data-in op and ends after the wait op.
- R7: With `mode_i`=1 (column change) the ops are: command 0x05, the two column bytes as in R3, command 0xE0, and a data-in op with `uop_arg_o`=`len_i`. All of them have `uop_arg_o`=0 apart from the data-in op.
- R8: While `uop_valid_o` is high and `uop_ready_i` is low, the op fields are held stable. After an op is accepted, no further op is offered until `rsp_valid_i` returns for it.
- R9: A response with `rsp_err_i`=1 ends the sequence. No further op is offered, and `done_o` and `err_o` pulse together in the next cycle.
- R10: `done_o` is a single-cycle pulse, and `err_o` is low with it on success. A `start_i` pulse while `busy_o` is high is ignored, and changes to the request inputs after the start do not alter the ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken while idle |
| mode_i | input | 1 | 0 = full page read, 1 = column change |
| big_dev_i | input | 1 | Device needs a third row byte |
| bus16_i | input | 1 | 16-bit data bus, column halved |
| page_i | input | 24 | Page (row) number |
| offset_i | input | 16 | Byte offset within the page |
| len_i | input | 16 | Data-in length, 0 = none for a full read |
| busy_o | output | 1 | Sequence in progress |
| uop_valid_o | output | 1 | Micro-op offered |
| uop_ready_i | input | 1 | Engine takes the micro-op |
| uop_kind_o | output | 2 | Micro-op kind |
| uop_byte_o | output | 8 | Command opcode or address byte |
| uop_dly_o | output | 8 | Post-delay in cycles |
| uop_arg_o | output | 16 | Wait time or data-in length |
| rsp_valid_i | input | 1 | Engine finished the accepted op |
| rsp_err_i | input | 1 | Engine reports failure |
| done_o | output | 1 | Sequence finished pulse |
| err_o | output | 1 | Sequence aborted, valid with done_o |

## Verification
The full read is run with a small device on an 8-bit bus and with a large device on a 16-bit bus with zero length. These two runs tell the two- and three-byte row forms apart and separate the halved column from the plain one, and they also show whether the data-in op is present or skipped. Column change is run on both bus widths to confirm that its shorter order and its longer post-delay are distinct from the full read. The engine model varies its ready and response latency from op to op, which exposes any field that moves while it is waiting. An error injected in the middle of the address bytes shows whether the abort really stops the stream. A start pulse with altered inputs during a busy sequence shows whether the request is captured only once.

// File: rtl/nprd_pkg.sv
package nprd_pkg;

  localparam int STEP_W = 4;
  localparam int ASEL_W = 3;

  typedef enum logic [1:0] {
    UOP_CMD  = 2'd0,
    UOP_ADDR = 2'd1,
    UOP_WAIT = 2'd2,
    UOP_DIN  = 2'd3
  } uop_kind_e;

  typedef enum logic [1:0] {
    ARG_NONE = 2'd0,
    ARG_TR   = 2'd1,
    ARG_LEN  = 2'd2
  } arg_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RESP  = 2'd2
  } seq_state_e;

  localparam logic [7:0] OPC_RD_OPEN = 8'h00;
  localparam logic [7:0] OPC_RD_GO   = 8'h30;
  localparam logic [7:0] OPC_CC_OPEN = 8'h05;
  localparam logic [7:0] OPC_CC_GO   = 8'hE0;

endpackage

// File: rtl/nprd_addr_fmt.sv
module nprd_addr_fmt
  import nprd_pkg::*;
#(
  parameter int OFF_W  = 16,
  parameter int PAGE_W = 24
) (
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              bus16_i,
  input  logic [ASEL_W-1:0] sel_i,
  output logic [7:0]        byte_o
);

  localparam int ROW_BYTES = (PAGE_W + 7) / 8;
  localparam int COL_BYTES = 2;
  localparam int N_BYTES   = COL_BYTES + ROW_BYTES;

  logic [OFF_W-1:0]         col_w;
  logic [15:0]              col_pad;
  logic [8*ROW_BYTES-1:0]   row_pad;
  logic [7:0]               abyte [N_BYTES];

  // word-addressed column on a 16-bit bus
  assign col_w   = bus16_i ? (offset_i >> 1) : offset_i;
  assign col_pad = 16'(col_w);
  assign row_pad = (8*ROW_BYTES)'(page_i);

  assign abyte[0] = col_pad[7:0];
  assign abyte[1] = col_pad[15:8];

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row
    assign abyte[COL_BYTES+g] = row_pad[8*g +: 8];
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < N_BYTES; i++) begin
      if (sel_i == ASEL_W'(i)) byte_o = abyte[i];
    end
  end

endmodule

// File: rtl/nprd_step_dec.sv
module nprd_step_dec
  import nprd_pkg::*;
#(
  parameter int DLY_W    = 8,
  parameter int TWB_CYC  = 12,
  parameter int TRR_CYC  = 4,
  parameter int TCCS_CYC = 40
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic              colchg_i,
  input  logic              big_dev_i,
  input  logic              len_zero_i,
  output uop_kind_e         kind_o,
  output logic [7:0]        opc_o,
  output logic [ASEL_W-1:0] asel_o,
  output logic [DLY_W-1:0]  dly_o,
  output arg_src_e          asrc_o,
  output logic              last_o,
  output logic [STEP_W-1:0] nxt_o
);

  localparam logic [STEP_W-1:0] RD_ROW_MID = STEP_W'(4);
  localparam logic [STEP_W-1:0] RD_GO_STEP = STEP_W'(6);

  always_comb begin
    kind_o = UOP_CMD;
    opc_o  = '0;
    asel_o = '0;
    dly_o  = '0;
    asrc_o = ARG_NONE;
    last_o = 1'b0;
    nxt_o  = step_i + STEP_W'(1);
    if (colchg_i) begin
      case (step_i)
        STEP_W'(0): opc_o = OPC_CC_OPEN;
        STEP_W'(1): begin kind_o = UOP_ADDR; asel_o = ASEL_W'(0); end
        STEP_W'(2): begin kind_o = UOP_ADDR; asel_o = ASEL_W'(1); end
        STEP_W'(3): begin opc_o = OPC_CC_GO; dly_o = DLY_W'(TCCS_CYC); end
        default: begin
          kind_o = UOP_DIN;
          asrc_o = ARG_LEN;
          last_o = 1'b1;
        end
      endcase
    end else begin
      case (step_i)
        STEP_W'(0): opc_o = OPC_RD_OPEN;
        STEP_W'(1), STEP_W'(2), STEP_W'(3), STEP_W'(4): begin
          kind_o = UOP_ADDR;
          asel_o = ASEL_W'(step_i - STEP_W'(1));
          if ((step_i == RD_ROW_MID) && !big_dev_i) nxt_o = RD_GO_STEP;
        end
        STEP_W'(5): begin kind_o = UOP_ADDR; asel_o = ASEL_W'(4); end
        STEP_W'(6): begin opc_o = OPC_RD_GO; dly_o = DLY_W'(TWB_CYC); end
        STEP_W'(7): begin
          kind_o = UOP_WAIT;
          dly_o  = DLY_W'(TRR_CYC);
          asrc_o = ARG_TR;
          last_o = len_zero_i;
        end
        default: begin
          kind_o = UOP_DIN;
          asrc_o = ARG_LEN;
          last_o = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/nand_page_rd_seq.sv
module nand_page_rd_seq
  import nprd_pkg::*;
#(
  parameter int PAGE_W   = 24,
  parameter int OFF_W    = 16,
  parameter int ARG_W    = 16,
  parameter int DLY_W    = 8,
  parameter int TWB_CYC  = 12,
  parameter int TRR_CYC  = 4,
  parameter int TCCS_CYC = 40,
  parameter int TR_CYC   = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              big_dev_i,
  input  logic              bus16_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [ARG_W-1:0]  len_i,
  output logic              busy_o,
  output logic              uop_valid_o,
  input  logic              uop_ready_i,
  output logic [1:0]        uop_kind_o,
  output logic [7:0]        uop_byte_o,
  output logic [DLY_W-1:0]  uop_dly_o,
  output logic [ARG_W-1:0]  uop_arg_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  output logic              done_o,
  output logic              err_o
);

  seq_state_e          st_q, st_d;
  logic [STEP_W-1:0]   step_q, step_d;
  logic                mode_q, big_q, b16_q;
  logic [PAGE_W-1:0]   page_q;
  logic [OFF_W-1:0]    off_q;
  logic [ARG_W-1:0]    len_q;
  logic                done_d, done_q, err_d, err_q;
  logic                req_en, step_en;

  uop_kind_e           dec_kind;
  logic [7:0]          dec_opc;
  logic [ASEL_W-1:0]   dec_asel;
  logic [DLY_W-1:0]    dec_dly;
  arg_src_e            dec_asrc;
  logic                dec_last;
  logic [STEP_W-1:0]   dec_nxt;
  logic [7:0]          addr_byte;

  nprd_step_dec #(
    .DLY_W   (DLY_W),
    .TWB_CYC (TWB_CYC),
    .TRR_CYC (TRR_CYC),
    .TCCS_CYC(TCCS_CYC)
  ) u_dec (
    .step_i    (step_q),
    .colchg_i  (mode_q),
    .big_dev_i (big_q),
    .len_zero_i(len_q == '0),
    .kind_o    (dec_kind),
    .opc_o     (dec_opc),
    .asel_o    (dec_asel),
    .dly_o     (dec_dly),
    .asrc_o    (dec_asrc),
    .last_o    (dec_last),
    .nxt_o     (dec_nxt)
  );

  nprd_addr_fmt #(
    .OFF_W (OFF_W),
    .PAGE_W(PAGE_W)
  ) u_addr (
    .offset_i(off_q),
    .page_i  (page_q),
    .bus16_i (b16_q),
    .sel_i   (dec_asel),
    .byte_o  (addr_byte)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    req_en  = 1'b0;
    step_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          req_en  = 1'b1;
          step_en = 1'b1;
          step_d  = '0;
          st_d    = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (uop_ready_i) st_d = ST_RESP;
      end
      ST_RESP: begin
        if (rsp_valid_i) begin
          if (rsp_err_i || dec_last) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            err_d  = rsp_err_i;
          end else begin
            step_en = 1'b1;
            step_d  = dec_nxt;
            st_d    = ST_ISSUE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (step_en) step_q <= step_d;
    end
  end

  // request capture, enabled only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      big_q  <= 1'b0;
      b16_q  <= 1'b0;
      page_q <= '0;
      off_q  <= '0;
      len_q  <= '0;
    end else if (req_en) begin
      mode_q <= mode_i;
      big_q  <= big_dev_i;
      b16_q  <= bus16_i;
      page_q <= page_i;
      off_q  <= offset_i;
      len_q  <= len_i;
    end
  end

  // micro-op fields
  always_comb begin
    uop_byte_o = '0;
    if (dec_kind == UOP_CMD)  uop_byte_o = dec_opc;
    if (dec_kind == UOP_ADDR) uop_byte_o = addr_byte;
    case (dec_asrc)
      ARG_TR:  uop_arg_o = ARG_W'(TR_CYC);
      ARG_LEN: uop_arg_o = len_q;
      default: uop_arg_o = '0;
    endcase
  end

  assign uop_kind_o  = dec_kind;
  assign uop_dly_o   = dec_dly;
  assign uop_valid_o = (st_q == ST_ISSUE);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid_o && !uop_ready_i) |=> (uop_valid_o && $stable(uop_kind_o) && $stable(uop_byte_o)
                                       && $stable(uop_dly_o) && $stable(uop_arg_o))); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid_o && uop_ready_i) |=> !uop_valid_o); // R8

  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESP && rsp_valid_i && rsp_err_i) |=> (done_o && err_o && !uop_valid_o && !busy_o)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o); // R10

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(page_q) && $stable(off_q) && $stable(len_q)); // R10

endmodule

// File: tb/nand_page_rd_seq_tb.sv
module nand_page_rd_seq_tb;

  logic        clk, rst_n;
  logic        start_i, mode_i, big_dev_i, bus16_i;
  logic [23:0] page_i;
  logic [15:0] offset_i, len_i;
  logic        busy_o, uop_valid_o, uop_ready_i;
  logic [1:0]  uop_kind_o;
  logic [7:0]  uop_byte_o, uop_dly_o;
  logic [15:0] uop_arg_o;
  logic        rsp_valid_i, rsp_err_i, done_o, err_o;

  nand_page_rd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .big_dev_i(big_dev_i), .bus16_i(bus16_i), .page_i(page_i),
    .offset_i(offset_i), .len_i(len_i), .busy_o(busy_o),
    .uop_valid_o(uop_valid_o), .uop_ready_i(uop_ready_i),
    .uop_kind_o(uop_kind_o), .uop_byte_o(uop_byte_o), .uop_dly_o(uop_dly_o),
    .uop_arg_o(uop_arg_o), .rsp_valid_i(rsp_valid_i), .rsp_err_i(rsp_err_i),
    .done_o(done_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [1:0]  kind;
    logic [7:0]  bval;
    logic [7:0]  dly;
    logic [15:0] arg;
    string       tag;
  } exp_op_t;

  exp_op_t q[$];
  int n_chk = 0, n_fail = 0;
  int err_at = -1;
  int op_idx = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] b, input logic [7:0] d,
                      input logic [15:0] a, input string t);
    exp_op_t e;
    e.kind = k; e.bval = b; e.dly = d; e.arg = a; e.tag = t;
    q.push_back(e);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // engine model and monitor
  initial begin
    uop_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_err_i = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && uop_valid_o) begin
        logic [1:0]  k0; logic [7:0] b0, d0; logic [15:0] a0;
        k0 = uop_kind_o; b0 = uop_byte_o; d0 = uop_dly_o; a0 = uop_arg_o;
        for (int w = 0; w < (op_idx % 3); w++) begin
          @(negedge clk);
          chk(uop_valid_o && uop_kind_o == k0 && uop_byte_o == b0 && uop_dly_o == d0
              && uop_arg_o == a0, "R8", "fields held while stalled",
              {uop_kind_o, uop_byte_o, uop_dly_o, uop_arg_o}, {k0, b0, d0, a0});
        end
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected micro-op", {k0, b0}, 0);
        end else begin
          exp_op_t e;
          e = q.pop_front();
          chk(k0 == e.kind, e.tag, "kind", k0, e.kind);
          chk(b0 == e.bval, e.tag, "byte", b0, e.bval);
          chk(d0 == e.dly,  "R5", "post delay", d0, e.dly);
          chk(a0 == e.arg,  e.tag, "arg", a0, e.arg);
        end
        uop_ready_i = 1'b1;
        @(negedge clk);
        uop_ready_i = 1'b0;
        for (int w = 0; w <= (op_idx % 2); w++) begin
          chk(!uop_valid_o, "R8", "no op before response", uop_valid_o, 0);
          @(negedge clk);
        end
        rsp_valid_i = 1'b1;
        rsp_err_i   = (op_idx == err_at);
        @(negedge clk);
        rsp_valid_i = 1'b0;
        rsp_err_i   = 1'b0;
        op_idx++;
      end
    end
  end

  task automatic run_seq(input bit md, input logic [23:0] pg, input logic [15:0] off,
                         input logic [15:0] ln, input bit big, input bit b16,
                         input int err_idx, input bit poke);
    logic [15:0] col;
    int n;
    bit seen;
    col = b16 ? (off >> 1) : off;
    n = 0;
    q.delete();
    if (md == 1'b0) begin
      push(2'd0, 8'h00, 8'd0, 16'd0, "R2");
      push(2'd1, col[7:0],  8'd0, 16'd0, "R3");
      push(2'd1, col[15:8], 8'd0, 16'd0, "R3");
      push(2'd1, pg[7:0],   8'd0, 16'd0, "R4");
      push(2'd1, pg[15:8],  8'd0, 16'd0, "R4");
      if (big) push(2'd1, pg[23:16], 8'd0, 16'd0, "R4");
      push(2'd0, 8'h30, 8'd12, 16'd0, "R2");
      push(2'd2, 8'h00, 8'd4, 16'd250, "R5");
      if (ln != 0) push(2'd3, 8'h00, 8'd0, ln, "R6");
    end else begin
      push(2'd0, 8'h05, 8'd0, 16'd0, "R7");
      push(2'd1, col[7:0],  8'd0, 16'd0, "R7");
      push(2'd1, col[15:8], 8'd0, 16'd0, "R7");
      push(2'd0, 8'hE0, 8'd40, 16'd0, "R7");
      push(2'd3, 8'h00, 8'd0, ln, "R7");
    end
    if (err_idx >= 0) begin
      while (q.size() > err_idx + 1) void'(q.pop_back());
    end
    err_at = err_idx;
    op_idx = 0;
    @(negedge clk);
    mode_i = md; page_i = pg; offset_i = off; len_i = ln;
    big_dev_i = big; bus16_i = b16; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R10", "busy after start", busy_o, 1);
    seen = 1'b0;
    while (!seen && n < 3000) begin
      @(negedge clk);
      n++;
      if (poke && n == 5) begin
        start_i = 1'b1; mode_i = ~md; page_i = ~pg; offset_i = ~off; len_i = ln + 16'd7;
        big_dev_i = ~big; bus16_i = ~b16;
      end
      if (poke && n == 6) start_i = 1'b0;
      if (done_o) seen = 1'b1;
    end
    chk(seen, "R10", "done seen", seen, 1);
    chk(err_o == (err_idx >= 0), "R9", "err with done", err_o, err_idx >= 0);
    chk(q.size() == 0, (err_idx >= 0) ? "R9" : "R2", "ops left unissued", q.size(), 0);
    @(negedge clk);
    chk(!done_o && !err_o, "R10", "done single pulse", done_o, 0);
    repeat (20) @(negedge clk);
    chk(!uop_valid_o && !busy_o, "R9", "quiet after end", uop_valid_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; big_dev_i = 1'b0; bus16_i = 1'b0;
    page_i = '0; offset_i = '0; len_i = '0;
    repeat (3) @(negedge clk);
    chk(!uop_valid_o && !done_o && !err_o && !busy_o, "R1", "outputs in reset",
        {uop_valid_o, done_o, err_o, busy_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!uop_valid_o && !done_o && !busy_o, "R1", "outputs after reset",
        {uop_valid_o, done_o, busy_o}, 0);
    run_seq(1'b0, 24'h0A0B0C, 16'h0123, 16'd512, 1'b0, 1'b0, -1, 1'b0);
    run_seq(1'b0, 24'h5A6B7C, 16'h0F02, 16'd0,   1'b1, 1'b1, -1, 1'b0);
    run_seq(1'b1, 24'h000000, 16'h0801, 16'd64,  1'b0, 1'b1, -1, 1'b0);
    run_seq(1'b1, 24'h123456, 16'h07FF, 16'd16,  1'b1, 1'b0, -1, 1'b0);
    run_seq(1'b0, 24'hC0FFEE, 16'h0044, 16'd128, 1'b1, 1'b0, 3, 1'b0);
    run_seq(1'b0, 24'h010203, 16'h0200, 16'd32,  1'b1, 1'b0, -1, 1'b1);
    run_seq(1'b1, 24'h000001, 16'h0010, 16'd8,   1'b0, 1'b0, 1, 1'b0);
    finish_run();
  end

endmodule